// File: doc/BRIEF.md
# Coherent Test Tone Phase Generator

This block steps the phase of a stimulus tone that stays exactly locked to the sample clock during mixed-signal testing. Software picks two integers: M, the number of tone cycles, and N, the number of samples in one unit test period. The tone frequency is then M times the primitive frequency, and the sample rate is N times it. The primitive frequency is the reciprocal of the unit test period. On each sample strobe the block emits a phase numerator and a sine table address. The numerator advances by M modulo N, so the sequence repeats exactly after N samples and never drifts.

The block also marks the first and the last sample of each unit test period. After every accepted load it runs a subtraction-based greatest common divisor engine, which reports whether M and N share a factor. When they share one, the samples fall on only N/gcd distinct phases and most converter codes are never exercised. With the pair M=51, N=400 (a 1020 Hz tone sampled at 8000 samples per second over 50 ms) every one of the 400 phases is visited. With M=50, N=400 only 8 phases are visited.

Top module: `coherent_phase_gen`

## Requirements
- R1: After a synchronous reset, valid, utp_start, utp_end, busy, done, not_coprime and cfg_err are all 0. The phase numerator and the sample counter are 0.
- R2: A load is accepted only while busy is 0. An accepted load sets busy to 1 and clears done, and the next sample then has phase 0 and sample index 0. A load presented while busy is 1 has no effect.
- R3: A load with n_in equal to 0, or with m_in greater than or equal to n_in, sets cfg_err to 1 and leaves M, N, the phase and the sample counter unchanged. The next accepted good load clears cfg_err.
- R4: The k-th sample after a load (k counted from 0) has phase equal to (k*M) mod N.
- R5: addr equals floor(phase * 2^K / N), with K=8 by default.
- R6: utp_start is 1 together with a sample whose index within the period is 0. utp_end is 1 together with a sample whose index is N-1. The index wraps from N-1 to 0. Both flags are 0 whenever valid is 0.
- R7: While the divisor engine runs, busy is 1. When it finishes, busy falls, done rises and stays at 1 until the next accepted load, and not_coprime is 1 exactly when gcd(M,N) is not 1. Here gcd(0,N) is N.
- R8: A strobe has no effect while busy is 1, or before any good load has been accepted.
- R9: An accepted strobe produces valid=1 with its outputs on the cycle after the strobe. valid lasts one cycle per strobe.
- R10: Over one full period with M=51, N=400, all 400 phases appear. With M=50, N=400, exactly 8 distinct phases appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load request for m_in and n_in |
| m_in | input | W | Tone cycles per unit test period |
| n_in | input | W | Samples per unit test period |
| strobe | input | 1 | Sample strobe |
| phase | output | W | Phase numerator of the current sample |
| addr | output | K | Sine table address |
| valid | output | 1 | Sample outputs are valid |
| utp_start | output | 1 | First sample of a unit test period |
| utp_end | output | 1 | Last sample of a unit test period |
| busy | output | 1 | Divisor engine running |
| done | output | 1 | Divisor result available |
| not_coprime | output | 1 | M and N share a factor |
| cfg_err | output | 1 | Last load was rejected |

## Verification
The assertions assume two things about the inputs. First, load and strobe are never raised in the same cycle. Second, m_in and n_in matter only in a cycle where load is 1. Under these assumptions the N that bounds each emitted phase is the one that was in force on the strobe cycle. The stimulus drives every input one time unit after a rising edge and never overlaps a load with a strobe. It waits for done before it strobes, except when it probes on purpose that strobes are ignored while the engine is busy.

// File: rtl/coherent_phase_gen.sv
module coherent_phase_gen #(
  parameter int W = 12,
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] n_in,
  input  logic         strobe,
  output logic [W-1:0] phase,
  output logic [K-1:0] addr,
  output logic         valid,
  output logic         utp_start,
  output logic         utp_end,
  output logic         busy,
  output logic         done,
  output logic         not_coprime,
  output logic         cfg_err
);
  localparam int PW = W + K;

  logic [W-1:0] m_q, n_q, num_q, cnt_q, ga, gb;
  logic         cfg_ok;

  logic take, load_ok, bad_cfg, last, gcd_fin;
  logic [W:0]    sum, wrap;
  logic [W-1:0]  num_nx;
  logic [PW-1:0] prod, divisor, quot;

  assign take    = strobe && cfg_ok && !busy;
  assign load_ok = load && !busy;
  assign bad_cfg = (n_in == '0) || (m_in >= n_in);
  assign last    = (cnt_q == n_q - 1'b1);
  assign gcd_fin = (ga == '0) || (ga == gb);

  assign sum    = {1'b0, num_q} + {1'b0, m_q};
  assign wrap   = sum - {1'b0, n_q};
  assign num_nx = (sum >= {1'b0, n_q}) ? wrap[W-1:0] : sum[W-1:0];

  assign prod    = {num_q, {K{1'b0}}};
  assign divisor = (n_q == '0) ? PW'(1) : {{K{1'b0}}, n_q};
  assign quot    = prod / divisor;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0; n_q <= '0; num_q <= '0; cnt_q <= '0;
      ga <= '0; gb <= '0; cfg_ok <= 1'b0;
      phase <= '0; addr <= '0; valid <= 1'b0;
      utp_start <= 1'b0; utp_end <= 1'b0;
      busy <= 1'b0; done <= 1'b0; not_coprime <= 1'b0; cfg_err <= 1'b0;
    end else begin
      valid     <= take;
      utp_start <= take && (cnt_q == '0);
      utp_end   <= take && last;
      if (take) begin
        phase <= num_q;
        addr  <= quot[K-1:0];
        num_q <= num_nx;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      if (load_ok) begin
        if (bad_cfg) begin
          cfg_err <= 1'b1;
        end else begin
          cfg_err     <= 1'b0;
          m_q         <= m_in;
          n_q         <= n_in;
          num_q       <= '0;
          cnt_q       <= '0;
          ga          <= m_in;
          gb          <= n_in;
          cfg_ok      <= 1'b1;
          busy        <= 1'b1;
          done        <= 1'b0;
          not_coprime <= 1'b0;
        end
      end else if (busy) begin
        if (gcd_fin) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          not_coprime <= (gb != W'(1));
        end else if (ga > gb) begin
          ga <= ga - gb;
        end else begin
          gb <= gb - ga;
        end
      end
    end
  end
endmodule

// File: rtl/coherent_phase_gen_chk.sv
module coherent_phase_gen_chk #(
  parameter int W = 12,
  parameter int K = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] m_in,
  input logic [W-1:0] n_in,
  input logic         strobe,
  input logic [W-1:0] phase,
  input logic         valid,
  input logic         utp_start,
  input logic         utp_end,
  input logic         busy,
  input logic         done,
  input logic         cfg_err,
  input logic         cfg_ok,
  input logic [W-1:0] n_q
);
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> (phase < $past(n_q)));

  assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (utp_start || utp_end) |-> valid);

  assert_busy_blocks_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !valid);

  assert_done_excl_busy_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_reject_keeps_n_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !busy && ((n_in == '0) || (m_in >= n_in))) |=> (cfg_err && $stable(n_q)));

  assert_strobe_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe && cfg_ok && !busy) |=> valid);

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !busy && (n_in != '0) && (m_in < n_in)) |=> (busy && !done));
endmodule

bind coherent_phase_gen coherent_phase_gen_chk #(.W(W), .K(K)) u_chk (
  .clk(clk), .rst(rst), .load(load), .m_in(m_in), .n_in(n_in),
  .strobe(strobe), .phase(phase), .valid(valid), .utp_start(utp_start),
  .utp_end(utp_end), .busy(busy), .done(done), .cfg_err(cfg_err),
  .cfg_ok(cfg_ok), .n_q(n_q)
);

// File: tb/tb_coherent_phase_gen.sv
module tb_coherent_phase_gen;
  localparam int W = 12;
  localparam int K = 8;

  logic         clk = 0;
  logic         rst = 1;
  logic         load = 0;
  logic [W-1:0] m_in = '0;
  logic [W-1:0] n_in = '0;
  logic         strobe = 0;
  logic [W-1:0] phase;
  logic [K-1:0] addr;
  logic valid, utp_start, utp_end, busy, done, not_coprime, cfg_err;

  always #2 clk = ~clk;

  coherent_phase_gen #(.W(W), .K(K)) dut (
    .clk(clk), .rst(rst), .load(load), .m_in(m_in), .n_in(n_in),
    .strobe(strobe), .phase(phase), .addr(addr), .valid(valid),
    .utp_start(utp_start), .utp_end(utp_end), .busy(busy), .done(done),
    .not_coprime(not_coprime), .cfg_err(cfg_err)
  );

  typedef struct {
    int ph;
    int ad;
    int st;
    int en;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  int k = 0;
  int cur_m = 0;
  int cur_n = 1;
  bit seen [4096];

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && valid) begin
      if (q.size() == 0) begin
        chk("R8 unexpected valid", 1, 0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk("R4 phase", int'(phase), e.ph);
        chk("R5 addr", int'(addr), e.ad);
        chk("R6 utp_start", int'(utp_start), e.st);
        chk("R6 utp_end", int'(utp_end), e.en);
        seen[phase] = 1'b1;
      end
    end
  end

  task automatic do_load(int m, int n);
    @(posedge clk); #1;
    load = 1; m_in = W'(m); n_in = W'(n);
    @(posedge clk); #1;
    load = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6000 && !done; i++) @(posedge clk);
    #1;
    chk("R7 done", int'(done), 1);
    chk("R7 busy low", int'(busy), 0);
  endtask

  task automatic run(int cnt);
    for (int i = 0; i < cnt; i++) begin
      item_t e;
      @(posedge clk); #1;
      e.ph = (k * cur_m) % cur_n;
      e.ad = (e.ph * (1 << K)) / cur_n;
      e.st = ((k % cur_n) == 0) ? 1 : 0;
      e.en = ((k % cur_n) == cur_n - 1) ? 1 : 0;
      q.push_back(e);
      k++;
      strobe = 1;
    end
    @(posedge clk); #1;
    strobe = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 scoreboard drained", q.size(), 0);
  endtask

  task automatic start(int m, int n);
    cur_m = m; cur_n = n; k = 0;
  endtask

  function automatic int count_seen();
    int c = 0;
    foreach (seen[i]) if (seen[i]) c++;
    return c;
  endfunction

  task automatic clear_seen();
    foreach (seen[i]) seen[i] = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0;
    @(negedge clk);
    chk("R1 valid", int'(valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    chk("R1 not_coprime", int'(not_coprime), 0);

    // R8: strobe before any configuration
    @(posedge clk); #1; strobe = 1;
    @(posedge clk); #1; strobe = 0;
    @(negedge clk);
    chk("R8 unconfigured strobe", int'(valid), 0);

    // R2: second load while busy is ignored
    do_load(7, 10);
    chk("R2 busy after load", int'(busy), 1);
    do_load(3, 9);
    wait_done();
    chk("R2 R7 gcd(7,10)", int'(not_coprime), 0);
    start(7, 10);
    run(23);

    // R10: shared factor
    do_load(50, 400);
    wait_done();
    chk("R7 gcd(50,400)", int'(not_coprime), 1);
    start(50, 400);
    clear_seen();
    run(400);
    chk("R10 phases M=50", count_seen(), 8);

    // R10: coprime pair
    do_load(51, 400);
    wait_done();
    chk("R7 gcd(51,400)", int'(not_coprime), 0);
    start(51, 400);
    clear_seen();
    run(400);
    chk("R10 phases M=51", count_seen(), 400);
    run(3);

    // R3: rejected loads keep configuration
    do_load(5, 0);
    chk("R3 n zero", int'(cfg_err), 1);
    run(4);
    do_load(9, 9);
    chk("R3 m>=n", int'(cfg_err), 1);
    run(2);
    do_load(3, 9);
    chk("R3 cleared", int'(cfg_err), 0);
    wait_done();
    chk("R7 gcd(3,9)", int'(not_coprime), 1);
    start(3, 9);
    run(10);

    // R8: strobes during a long divisor run
    do_load(1, 4095);
    @(posedge clk); #1; strobe = 1;
    repeat (3) @(posedge clk);
    #1; strobe = 0;
    @(negedge clk);
    chk("R8 busy strobe", int'(valid), 0);
    chk("R7 still busy", int'(busy), 1);
    wait_done();
    chk("R7 gcd(1,4095)", int'(not_coprime), 0);
    start(1, 4095);
    run(5);

    // zero tone and single-sample period
    do_load(0, 5);
    wait_done();
    chk("R7 gcd(0,5)", int'(not_coprime), 1);
    start(0, 5);
    run(6);
    do_load(0, 1);
    wait_done();
    chk("R7 gcd(0,1)", int'(not_coprime), 0);
    start(0, 1);
    run(3);

    summary();
  end
endmodule